// File: doc/BRIEF.md
# Quadrature Burst Generator

The block produces two square waves, a leading and a lagging phase, a quarter period apart. One period counter drives both. After a start strobe it emits an exact number of full quadrature cycles and then stops in hardware, on the clock edge that ends the last cycle. Software does not need to take an interrupt to cut the burst short, so interrupt latency cannot add pulses when several channels run at the same time. Each instance holds all of its own state, so many copies can run side by side and each one stops on its own count.

The period, in clock cycles, is the clock frequency divided by the wanted output frequency. A target of zero makes the generator run without end until reset. A counter output reports how many cycles have completed so far.

Top module: `qpulse_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `pha_o` and `phb_o` are 0 and `cycles_o` is 0.
- R2: A start strobe seen while idle captures `period_i` and `target_i` and clears `cycles_o`. `busy_o` is 1 from the next cycle, and that cycle is position 0 of the first period.
- R3: While busy, the period position steps 0, 1, ..., P-1 and then wraps to 0, so one period lasts P clocks. `phb_o` is 1 exactly when the position is at least P/2, with integer division.
- R4: While busy, `pha_o` is 1 exactly when the position is at least P/4 and below P/4 + P/2, with integer division. This makes `pha_o` rise while `phb_o` is low, and `phb_o` rise while `pha_o` is high.
- R5: `cycles_o` goes up by one on the clock edge that ends each period. It holds its value after the burst and clears only on the next accepted start.
- R6: With a nonzero target N, `busy_o` falls exactly N*P clocks after it rose. While idle, both phases are 0, so no partial edge appears after the last cycle, and `cycles_o` reads N.
- R7: `done_o` is high for exactly one cycle, in the first cycle in which `busy_o` is low after a burst. It is never high at any other time.
- R8: A target of 0 keeps the generator running with no automatic stop.
- R9: A start strobe that arrives while busy is ignored. It does not change the burst length, the period or the target.
- R10: A captured period below 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, acted on only when idle |
| period_i | input | CNT_W | Period length in clocks, captured at start |
| target_i | input | TGT_W | Number of cycles to emit, 0 means no limit |
| pha_o | output | 1 | Leading phase |
| phb_o | output | 1 | Lagging phase |
| busy_o | output | 1 | A burst is in progress |
| done_o | output | 1 | One-cycle pulse when a burst ends |
| cycles_o | output | TGT_W | Number of cycles completed in the current or last burst |

## Verification
The hardest case to reach from the ports is a start strobe, carrying a different period and target, that lands in the middle of a burst. The bench drives such a strobe a few cycles into a burst and checks three things: the waveform still follows the captured period, the stop comes at the original count, and `cycles_o` ends at the first target. A second hard case is an endless run with target 0. The bench follows it for many periods and then ends it with reset. Odd periods and periods below the minimum go through the same vector table, so the truncating quarter points and the clamp are checked cycle by cycle.

// File: rtl/qpg_pkg.sv
package qpg_pkg;
  typedef enum logic {QS_IDLE = 1'b0, QS_RUN = 1'b1} qpg_state_e;
  localparam int unsigned QPG_MIN_PERIOD = 4;
endpackage

// File: rtl/qpg_timebase.sv
module qpg_timebase #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] period_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(qpg_pkg::QPG_MIN_PERIOD);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] pos_q, pos_d;
  logic             period_en, pos_en;

  // period capture with clamp to the minimum
  always_comb begin
    period_en = load_i;
    period_d  = (period_i < MIN_P) ? MIN_P : period_i;
  end

  assign wrap_o = run_i && (pos_q == period_q - ONE);

  always_comb begin
    pos_en = load_i || run_i;
    if (load_i || wrap_o) pos_d = '0;
    else                  pos_d = pos_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= MIN_P;
      pos_q    <= '0;
    end else begin
      if (period_en) period_q <= period_d;
      if (pos_en)    pos_q    <= pos_d;
    end
  end

  assign pos_o    = pos_q;
  assign period_o = period_q;
endmodule

// File: rtl/qpg_cycles.sv
module qpg_cycles #(
  parameter int unsigned TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             wrap_i,
  input  logic [TGT_W-1:0] target_i,
  output logic [TGT_W-1:0] count_o,
  output logic             last_o,
  output logic             unlimited_o
);
  logic [TGT_W-1:0] tgt_q, count_q, count_d;
  logic [TGT_W:0]   count_inc;
  logic             count_en;

  assign count_inc = {1'b0, count_q} + {{TGT_W{1'b0}}, 1'b1};

  always_comb begin
    count_en = load_i || wrap_i;
    count_d  = load_i ? '0 : count_inc[TGT_W-1:0];
  end

  // terminal count: decided in the same cycle as the end of the period
  assign unlimited_o = (tgt_q == '0);
  assign last_o      = wrap_i && !unlimited_o && (count_inc >= {1'b0, tgt_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      count_q <= '0;
    end else begin
      if (load_i)   tgt_q   <= target_i;
      if (count_en) count_q <= count_d;
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/qpg_ctrl.sv
module qpg_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic load_o,
  output logic busy_o,
  output logic done_o
);
  import qpg_pkg::*;

  qpg_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      QS_IDLE: if (start_i) begin
        load_o  = 1'b1;
        state_d = QS_RUN;
      end
      QS_RUN: if (last_i) begin
        state_d = QS_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= QS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q == QS_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/qpg_phase.sv
module qpg_phase #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             busy_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             pha_o,
  output logic             phb_o
);
  logic [CNT_W-1:0] quarter, half, three_q;

  always_comb begin
    quarter = period_i >> 2;
    half    = period_i >> 1;
    three_q = quarter + half;
    phb_o   = busy_i && (pos_i >= half);
    pha_o   = busy_i && (pos_i >= quarter) && (pos_i < three_q);
  end
endmodule

// File: rtl/qpulse_gen.sv
module qpulse_gen #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [TGT_W-1:0] target_i,
  output logic             pha_o,
  output logic             phb_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [TGT_W-1:0] cycles_o
);
  logic             load, busy, wrap, last, tgt_zero;
  logic [CNT_W-1:0] pos, period_q;

  qpg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last),
    .load_o(load), .busy_o(busy), .done_o(done_o)
  );

  qpg_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .load_i(load), .run_i(busy),
    .period_i(period_i), .pos_o(pos), .period_o(period_q), .wrap_o(wrap)
  );

  qpg_cycles #(.TGT_W(TGT_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .load_i(load), .wrap_i(wrap),
    .target_i(target_i), .count_o(cycles_o), .last_o(last),
    .unlimited_o(tgt_zero)
  );

  qpg_phase #(.CNT_W(CNT_W)) u_ph (
    .busy_i(busy), .pos_i(pos), .period_i(period_q),
    .pha_o(pha_o), .phb_o(phb_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/qpulse_gen_chk.sv
module qpulse_gen_chk #(
  parameter int unsigned TGT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             pha_o,
  input logic             phb_o,
  input logic [TGT_W-1:0] cycles_o,
  input logic             tgt_zero
);
  a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && cycles_o == '0));

  a_r3_b_lags_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phb_o) |-> pha_o);

  a_r4_a_leads_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pha_o) |-> !phb_o);

  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |->
      (cycles_o == $past(cycles_o) || cycles_o == $past(cycles_o) + 1'b1));

  a_r6_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!pha_o && !phb_o));

  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r7_end_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  a_r8_no_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tgt_zero) |=> busy_o);
endmodule

bind qpulse_gen qpulse_gen_chk #(.TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .pha_o(pha_o), .phb_o(phb_o), .cycles_o(cycles_o),
  .tgt_zero(tgt_zero)
);

// File: tb/qpulse_gen_test.sv
module qpulse_gen_test;
  localparam int CNT_W = 32;
  localparam int TGT_W = 16;
  localparam int NV = 6;
  // columns: period, target
  localparam int VEC [NV][2] = '{'{8, 3}, '{5, 2}, '{12, 1}, '{2, 2}, '{4, 4}, '{7, 3}};

  logic             clk, rst_n, start_i;
  logic [CNT_W-1:0] period_i;
  logic [TGT_W-1:0] target_i;
  logic             pha_o, phb_o, busy_o, done_o;
  logic [TGT_W-1:0] cycles_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  qpulse_gen #(.CNT_W(CNT_W), .TGT_W(TGT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .period_i(period_i),
    .target_i(target_i), .pha_o(pha_o), .phb_o(phb_o), .busy_o(busy_o),
    .done_o(done_o), .cycles_o(cycles_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input int p, input int n);
    @(negedge clk);
    start_i  = 1'b1;
    period_i = CNT_W'(p);
    target_i = TGT_W'(n);
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  // expected outputs at sample k after an accepted start
  task automatic expect_at(input int pe, input int n, input int k,
                           output bit eb, output bit ea, output bit ebb,
                           output bit ed, output int ec);
    int c;
    eb  = (n == 0) || (k < n * pe);
    c   = k % pe;
    ebb = eb && (c >= pe / 2);
    ea  = eb && (c >= pe / 4) && (c < pe / 4 + pe / 2);
    ed  = (n != 0) && (k == n * pe);
    ec  = (n != 0 && k >= n * pe) ? n : k / pe;
  endtask

  task automatic check_reset_state(input string tag);
    check(busy_o == 0 && done_o == 0, {tag, " R1 busy/done"}, {busy_o, done_o}, 0);
    check(pha_o == 0 && phb_o == 0, {tag, " R1 phases"}, {pha_o, phb_o}, 0);
    check(cycles_o == 0, {tag, " R1 cycles"}, int'(cycles_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; period_i = '0; target_i = '0;
    repeat (3) @(negedge clk);
    check_reset_state("reset");
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      int p, n, pe, mb, ma, mc, dcnt, dk;
      bit eb, ea, ebb, ed; int ec;
      p = VEC[v][0]; n = VEC[v][1];
      pe = (p < 4) ? 4 : p;   // R10 clamp
      mb = 0; ma = 0; mc = 0; dcnt = 0; dk = -1;
      pulse_start(p, n);
      for (int k = 0; k < n * pe + 4; k++) begin
        expect_at(pe, n, k, eb, ea, ebb, ed, ec);
        if (busy_o != eb) mb++;
        if (pha_o != ea || phb_o != ebb) ma++;
        if (int'(cycles_o) != ec) mc++;
        if (done_o) begin dcnt++; dk = k; end
        @(negedge clk);
      end
      check(mb == 0, $sformatf("R2/R6 busy window p=%0d", p), mb, 0);
      check(ma == 0, $sformatf("R3/R4/R10 phases p=%0d", p), ma, 0);
      check(mc == 0, $sformatf("R5 cycle count p=%0d", p), mc, 0);
      check(dcnt == 1 && dk == n * pe, $sformatf("R7 done p=%0d", p), dk, n * pe);
      check(int'(cycles_o) == n, "R6 final count", int'(cycles_o), n);
    end

    // R9: start with other settings during a burst is ignored
    begin
      int mism; bit eb, ea, ebb, ed; int ec;
      mism = 0;
      pulse_start(8, 2);
      for (int k = 0; k < 20; k++) begin
        expect_at(8, 2, k, eb, ea, ebb, ed, ec);
        if (busy_o != eb || pha_o != ea || phb_o != ebb || int'(cycles_o) != ec) mism++;
        if (k == 3) begin start_i = 1'b1; period_i = 32'd4; target_i = 16'd1; end
        else start_i = 1'b0;
        @(negedge clk);
      end
      check(mism == 0, "R9 restart ignored", mism, 0);
      check(int'(cycles_o) == 2, "R9 length kept", int'(cycles_o), 2);
    end

    // R8: target 0 runs on
    begin
      int mism; bit eb, ea, ebb, ed; int ec;
      mism = 0;
      pulse_start(4, 0);
      for (int k = 0; k < 60; k++) begin
        expect_at(4, 0, k, eb, ea, ebb, ed, ec);
        if (busy_o != 1'b1 || pha_o != ea || phb_o != ebb || done_o) mism++;
        if (k == 48 && int'(cycles_o) != 12) mism++;
        @(negedge clk);
      end
      check(mism == 0, "R8 continuous run", mism, 0);
      check(busy_o == 1'b1, "R8 still busy", busy_o, 1);
      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state("rerst");
      rst_n = 1'b1;
      @(negedge clk);
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule